// File: doc/BRIEF.md
# Programmable Eight-Input Interrupt Controller

This block gathers eight interrupt request lines for one processor. It raises a single interrupt output whenever a request is eligible. When the processor acknowledges, the block returns an 8-bit vector for the request it chose. Software talks to it over a small register bus: a one-bit address selects the command port (0) or the data port (1), and single-cycle read and write strobes carry 8-bit data.

**Initialization.** After reset, or at any later time, software sends an initialization sequence. It chooses:
- edge or level sensing,
- the vector base,
- an optional cascade configuration byte, which is only stored,
- an optional mode byte that can enable automatic end-of-interrupt.

**Normal operation.** Once initialized, data-port writes load the mask. Command-port writes issue one of three things:
- end-of-interrupt commands,
- a priority rotation that names the lowest-priority input,
- a choice of whether command-port reads return pending requests or in-service bits.

**Sequencer states.** The initialization sequencer has four states:
- `ST_READY` is normal operation.
- `ST_WANT_BASE` waits for the vector base.
- `ST_WANT_CASC` waits for the cascade byte.
- `ST_WANT_MODE` waits for the mode byte.

**Sequencer transitions.**
- A command write with bit 4 set moves any state to `ST_WANT_BASE`.
- A data write in `ST_WANT_BASE` moves to `ST_WANT_CASC` if cascade was requested. Otherwise it moves to `ST_WANT_MODE` if a mode byte was requested, and otherwise to `ST_READY`.
- A data write in `ST_WANT_CASC` moves to `ST_WANT_MODE` or `ST_READY` by the same rule.
- A data write in `ST_WANT_MODE` moves to `ST_READY`.

Top module: `prog_irq_ctrl`

## Requirements
- R1: After reset the mask, pending-request and in-service registers read 0, the interrupt output is low, the vector base is 0, and input 0 has the highest priority and input 7 the lowest.
- R2: A command write with bit 4 set starts initialization: mask becomes 0xff, in-service and pending bits clear, reads return pending requests, and bit 3 of that byte selects level sensing (1) or edge sensing (0).
- R3: The first data write after R2 sets the vector base; an acknowledged input n yields vector base+n.
- R4: The cascade byte is expected only when bit 1 of the start byte is 0, and the mode byte only when bit 0 is 1; data writes consumed by the sequence never change the mask, and the cascade byte appears on `casc_cfg`.
- R5: Mode byte bit 1 enables automatic end-of-interrupt: an acknowledge then sets no in-service bit.
- R6: In `ST_READY` a data write loads the mask, a data-port read returns the mask, and a masked request never asserts `irq_out`.
- R7: Command byte 0x0a makes command-port reads return pending requests, 0x0b makes them return in-service bits.
- R8: Command byte 0xc0|n makes input n lowest priority, so priority runs n+1, n+2, ... wrapping to n.
- R9: On `ack` the block picks the highest-priority eligible input, sets its in-service bit, clears its edge-latched pending bit, and presents `vec_out` with `vec_valid` high for exactly the next cycle.
- R10: A request is eligible only if it has strictly higher priority than every set in-service bit.
- R11: Command 0x20 clears the highest-priority set in-service bit; command 0x60|n clears in-service bit n.
- R12: If nothing is eligible at `ack`, the vector is base+7 and no in-service bit is set.
- R13: In edge mode a request pends only after a rising input and is dropped if the input falls before acknowledge; an input held high after acknowledge does not re-request. In level mode the pending bit follows the input.
- R14: `irq_out` reflects eligibility one clock after a request input changes and in the cycle after any mask write, end-of-interrupt or acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 8 | Interrupt request lines |
| addr | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is zero when low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| ack | input | 1 | Interrupt acknowledge pulse |
| irq_out | output | 1 | Interrupt request to processor |
| vec_out | output | 8 | Vector for the last acknowledge |
| vec_valid | output | 1 | High the cycle after `ack` |
| casc_cfg | output | 8 | Stored cascade configuration byte |

## Verification
A stale in-service bit shows up in two ways: `irq_out` stays low for requests that should be served, and a 0x0b read shows the extra bit. Both are visible right after the next request edge. A wrong priority pointer or vector base appears as a wrong `vec_out` on the next acknowledge. A broken edge latch shows as `irq_out` rising again while an already served input stays high. A sequencer stuck in an initialization state shows as a data write that leaves the mask unchanged, visible on the following data-port read.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [1:0] {
        ST_READY,
        ST_WANT_BASE,
        ST_WANT_CASC,
        ST_WANT_MODE
    } seq_state_t;

    localparam logic [2:0] OP_EOI_ANY  = 3'b001;
    localparam logic [2:0] OP_EOI_SPEC = 3'b011;
    localparam logic [2:0] OP_SET_LOW  = 3'b110;
endpackage

// File: rtl/irq_init_seq.sv
module irq_init_seq
    import irq_ctrl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic          dat_wr,
    input  logic [DW-1:0] wdata,
    output logic          ready,
    output logic          start_stb,
    output logic          base_stb,
    output logic          casc_stb,
    output logic          mode_stb
);
    seq_state_t state, nxt;
    logic       need_casc, need_mode;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_READY;
            need_casc <= 1'b0;
            need_mode <= 1'b0;
        end else begin
            state <= nxt;
            if (start_stb) begin
                need_casc <= ~wdata[1];
                need_mode <= wdata[0];
            end
        end
    end

    // next state and strobes
    always_comb begin
        nxt       = state;
        start_stb = 1'b0;
        base_stb  = 1'b0;
        casc_stb  = 1'b0;
        mode_stb  = 1'b0;
        if (cmd_wr && wdata[4]) begin
            start_stb = 1'b1;
            nxt       = ST_WANT_BASE;
        end else begin
            unique case (state)
                ST_READY: ;
                ST_WANT_BASE: if (dat_wr) begin
                    base_stb = 1'b1;
                    nxt = need_casc ? ST_WANT_CASC :
                          (need_mode ? ST_WANT_MODE : ST_READY);
                end
                ST_WANT_CASC: if (dat_wr) begin
                    casc_stb = 1'b1;
                    nxt = need_mode ? ST_WANT_MODE : ST_READY;
                end
                ST_WANT_MODE: if (dat_wr) begin
                    mode_stb = 1'b1;
                    nxt = ST_READY;
                end
                default: nxt = ST_READY;
            endcase
        end
    end

    assign ready = (state == ST_READY);
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
    parameter int N_IN  = 8,
    parameter int IDX_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  vec,
    input  logic [IDX_W-1:0] low_pri,
    output logic             any,
    output logic [IDX_W-1:0] idx,
    output logic [N_IN-1:0]  above
);
    // scan from the input just after low_pri; above = bits ranked before the winner
    always_comb begin
        any   = 1'b0;
        idx   = '0;
        above = '0;
        for (int k = 0; k < N_IN; k++) begin
            int pos;
            pos = (int'(low_pri) + 1 + k) % N_IN;
            if (!any) begin
                if (vec[pos]) begin
                    any = 1'b1;
                    idx = IDX_W'(pos);
                end else begin
                    above[pos] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] req_in,
    input  logic          addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          ack,
    output logic          irq_out,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    output logic [DW-1:0] casc_cfg
);
    localparam int N_IN  = DW;
    localparam int IDX_W = $clog2(N_IN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_IN - 1);

    logic [N_IN-1:0]  mask, irr, isr, req_prev, irr_nxt;
    logic [DW-1:0]    base;
    logic             auto_eoi, level_mode, sel_isr;
    logic [IDX_W-1:0] low_pri;

    logic cmd_w, dat_w, seq_ready;
    logic start_stb, base_stb, casc_stb, mode_stb;
    logic ocw2, ocw3;

    logic             isr_any, req_any;
    logic [IDX_W-1:0] isr_top, req_idx;
    logic [N_IN-1:0]  isr_above, req_above, eligible;
    logic [N_IN-1:0]  eoi_clr, ack_take, ack_set;

    assign cmd_w = wr_en & ~addr;
    assign dat_w = wr_en & addr;

    irq_init_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_w), .dat_wr(dat_w),
        .wdata(wdata), .ready(seq_ready), .start_stb(start_stb),
        .base_stb(base_stb), .casc_stb(casc_stb), .mode_stb(mode_stb)
    );

    assign ocw2 = cmd_w & seq_ready & ~wdata[4] & ~wdata[3];
    assign ocw3 = cmd_w & seq_ready & ~wdata[4] &  wdata[3];

    irq_prio_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_isr_pick (
        .vec(isr), .low_pri(low_pri), .any(isr_any), .idx(isr_top), .above(isr_above)
    );

    assign eligible = irr & ~mask & isr_above;

    irq_prio_pick #(.N_IN(N_IN), .IDX_W(IDX_W)) u_req_pick (
        .vec(eligible), .low_pri(low_pri), .any(req_any), .idx(req_idx), .above(req_above)
    );

    assign irq_out = req_any;

    always_comb begin
        eoi_clr = '0;
        if (ocw2 && wdata[7:5] == OP_EOI_ANY && isr_any)
            eoi_clr = N_IN'(1) << isr_top;
        else if (ocw2 && wdata[7:5] == OP_EOI_SPEC)
            eoi_clr = N_IN'(1) << wdata[IDX_W-1:0];
    end

    assign ack_take = (ack && req_any) ? (N_IN'(1) << req_idx) : '0;
    assign ack_set  = auto_eoi ? '0 : ack_take;

    // per-input pending latch
    for (genvar g = 0; g < N_IN; g++) begin : g_irr
        assign irr_nxt[g] = level_mode ? req_in[g]
                          : (req_in[g] & (irr[g] | ~req_prev[g]) & ~ack_take[g]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask       <= '0;
            irr        <= '0;
            isr        <= '0;
            req_prev   <= '0;
            base       <= '0;
            casc_cfg   <= '0;
            auto_eoi   <= 1'b0;
            level_mode <= 1'b0;
            sel_isr    <= 1'b0;
            low_pri    <= LAST_IDX;
            vec_out    <= '0;
            vec_valid  <= 1'b0;
        end else begin
            req_prev  <= req_in;
            vec_valid <= ack;
            if (ack)
                vec_out <= base + DW'(req_any ? req_idx : LAST_IDX);
            if (start_stb) begin
                mask       <= '1;
                irr        <= '0;
                isr        <= '0;
                auto_eoi   <= 1'b0;
                sel_isr    <= 1'b0;
                low_pri    <= LAST_IDX;
                level_mode <= wdata[3];
            end else begin
                irr <= irr_nxt;
                isr <= (isr & ~eoi_clr) | ack_set;
                if (base_stb) base <= wdata;
                if (casc_stb) casc_cfg <= wdata;
                if (mode_stb) auto_eoi <= wdata[1];
                if (dat_w && seq_ready) mask <= wdata;
                if (ocw3 && wdata[1]) sel_isr <= wdata[0];
                if (ocw2 && wdata[7:5] == OP_SET_LOW) low_pri <= wdata[IDX_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en)
            rdata = addr ? mask : (sel_isr ? isr : irr);
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ack,
    input logic          wr_en,
    input logic          addr,
    input logic [DW-1:0] wdata,
    input logic          irq_out,
    input logic          vec_valid,
    input logic [DW-1:0] mask,
    input logic [DW-1:0] irr,
    input logic [DW-1:0] isr,
    input logic          auto_eoi,
    input logic          seq_ready
);
    a_r6_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr && seq_ready) |=> (mask == $past(wdata)));

    a_r2_start_masks_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr && wdata[4]) |=> (mask == '1));

    a_r9_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);

    a_r9_vec_single: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);

    a_r5_auto_no_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && auto_eoi) |=> ((isr & ~$past(isr)) == '0));

    a_r6_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~mask) != '0));
endmodule

bind prog_irq_ctrl irq_ctrl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack(ack), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq_out(irq_out), .vec_valid(vec_valid), .mask(mask),
    .irr(irr), .isr(isr), .auto_eoi(auto_eoi), .seq_ready(seq_ready)
);

// File: tb/tb_prog_irq_ctrl.sv
module tb_prog_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] req_in = '0;
    logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, ack = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, vec_out, casc_cfg;
    logic       irq_out, vec_valid;
    int         errors = 0, checks = 0;
    int unsigned seed = 32'd4242;
    logic [7:0] r, v;

    always #2 clk = ~clk;

    prog_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_in(req_in), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .ack(ack), .irq_out(irq_out),
        .vec_out(vec_out), .vec_valid(vec_valid), .casc_cfg(casc_cfg)
    );

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic setreq(input logic [7:0] q);
        @(negedge clk); req_in = q;
        @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] vv);
        @(negedge clk); ack = 1'b1;
        @(negedge clk); ack = 1'b0;
        chk("R9 vec_valid", {7'd0, vec_valid}, 8'd1);
        vv = vec_out;
    endtask

    // highest-priority set bit after lowest input lp, or -1
    function automatic int exp_pick(input logic [7:0] q, input logic [7:0] m, input int lp);
        for (int k = 0; k < 8; k++) begin
            int p;
            p = (lp + 1 + k) % 8;
            if (q[p] && !m[p]) return p;
        end
        return -1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 irq", {7'd0, irq_out}, 8'd0);
        rd(1'b1, r); chk("R1 mask", r, 8'h00);
        rd(1'b0, r); chk("R1 irr", r, 8'h00);
        setreq(8'h81);
        do_ack(v); chk("R1 default order vec", v, 8'h00);
        wr(1'b0, 8'h20); setreq(8'h00);

        // R2/R3/R4 init with cascade and mode bytes
        wr(1'b0, 8'h11);
        wr(1'b1, 8'h20);
        wr(1'b1, 8'h04);
        rd(1'b1, r); chk("R4 casc byte not mask", r, 8'hff);
        wr(1'b1, 8'h01);
        rd(1'b1, r); chk("R2 mask after init", r, 8'hff);
        chk("R4 casc_cfg", casc_cfg, 8'h04);

        // R6 mask and R14 re-evaluation
        wr(1'b1, 8'h20);
        rd(1'b1, r); chk("R6 mask read", r, 8'h20);
        setreq(8'h20);
        chk("R6 masked silent", {7'd0, irq_out}, 8'd0);
        wr(1'b1, 8'h00);
        chk("R14 irq after unmask", {7'd0, irq_out}, 8'd1);
        wr(1'b0, 8'h0a);
        rd(1'b0, r); chk("R7 irr read", r, 8'h20);
        do_ack(v); chk("R3 vector base+5", v, 8'h25);
        rd(1'b0, r); chk("R13 edge irr cleared", r, 8'h00);
        chk("R13 held input no rerequest", {7'd0, irq_out}, 8'd0);
        wr(1'b0, 8'h0b);
        rd(1'b0, r); chk("R7 R9 isr read", r, 8'h20);

        // R10 blocking, R11 EOI
        setreq(8'h60);
        chk("R10 lower blocked", {7'd0, irq_out}, 8'd0);
        setreq(8'h64);
        chk("R10 higher passes", {7'd0, irq_out}, 8'd1);
        do_ack(v); chk("R9 vec input2", v, 8'h22);
        rd(1'b0, r); chk("R9 isr two bits", r, 8'h24);
        wr(1'b0, 8'h20);
        rd(1'b0, r); chk("R11 nonspecific", r, 8'h20);
        wr(1'b0, 8'h65);
        rd(1'b0, r); chk("R11 specific", r, 8'h00);
        chk("R14 irq after eoi", {7'd0, irq_out}, 8'd1);
        do_ack(v); chk("R9 vec input6", v, 8'h26);
        wr(1'b0, 8'h20); setreq(8'h00);

        // R8 rotation
        wr(1'b0, 8'hc2);
        setreq(8'h85);
        do_ack(v); chk("R8 lowest=2 picks 7", v, 8'h27);
        wr(1'b0, 8'h20);
        do_ack(v); chk("R8 then 0", v, 8'h20);
        wr(1'b0, 8'h20); setreq(8'h00);

        // R12 spurious
        setreq(8'h08); setreq(8'h00);
        do_ack(v); chk("R12 spurious vec", v, 8'h27);
        rd(1'b0, r); chk("R12 isr clear", r, 8'h00);

        // random phase
        for (int it = 0; it < 40; it++) begin
            int lp, pk;
            logic [7:0] m, q;
            lp = int'($urandom(seed) % 8); seed = seed + 1;
            m  = 8'($urandom(seed)); seed = seed + 1;
            q  = 8'($urandom(seed)); seed = seed + 1;
            setreq(8'h00);
            wr(1'b1, m);
            wr(1'b0, 8'hc0 | 8'(lp));
            setreq(q);
            pk = exp_pick(q, m, lp);
            chk("R6 R14 random irq", {7'd0, irq_out}, (pk >= 0) ? 8'd1 : 8'd0);
            if (pk >= 0) begin
                do_ack(v); chk("R8 R9 random vec", v, 8'h20 + 8'(pk));
                rd(1'b0, r); chk("R9 random isr", r, 8'd1 << pk);
                wr(1'b0, 8'h20);
                rd(1'b0, r); chk("R11 random eoi", r, 8'h00);
            end
        end
        setreq(8'h00);

        // R5 auto EOI, R13 level, R4 skipped cascade byte
        wr(1'b0, 8'h1b);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h03);
        rd(1'b1, r); chk("R4 mode follows base", r, 8'hff);
        chk("R4 casc kept", casc_cfg, 8'h04);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h0b);
        setreq(8'h02);
        do_ack(v); chk("R5 vec", v, 8'h41);
        rd(1'b0, r); chk("R5 no isr", r, 8'h00);
        chk("R13 level still requests", {7'd0, irq_out}, 8'd1);
        setreq(8'h00);
        chk("R13 level drops", {7'd0, irq_out}, 8'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule